// File: doc/BRIEF.md
# Buck Converter Soft-Start and Hiccup Sequencer

This block is the digital supervisor of a synchronous buck controller. It stands in for the soft-start capacitor with a ramp counter and walks the converter through its operating phases. The ramp code it produces clamps the regulation reference. From the phase and the ramp code it derives the two driver enables, a flag that allows reverse (sink) current, and a flag that marks constant-current limiting during start-up. Flags from outside comparators feed it: supply good, input good, over-current, over-temperature trip, temperature recovered and over-voltage.

There are five states, and `phase` shows them as 3-bit codes: OFF = 0, START = 1, RUN = 2, HICCUP = 3, THERMAL = 4. The transitions are:
- power-up: OFF to START.
- soft-start done: START to RUN.
- over-current trip: RUN to HICCUP.
- hiccup restart: HICCUP to START.
- thermal trip: any state to THERMAL.
- thermal recovery: THERMAL to START or to OFF.
- power loss: START, RUN or HICCUP to OFF.

Every phase change takes effect on the clock edge after its cause. In the default parameters one ramp unit is 1 mV of the modelled soft-start voltage.

Top module: `softstart_seq`

## Requirements
- R1: While `vcc_ok` and `vin_ok` are not both high, the block stays in or goes to OFF (`phase` = 0) on the next edge, with `ramp_code` at 0 and both drivers off. Raising both flags in OFF moves the block to START (`phase` = 1) on the next edge.
- R2: In START and RUN the ramp code rises by 35 per clock while it is below 500, and by 10 per clock at 500 or above. It saturates at 4000.
- R3: In START and RUN, with no over-voltage, both drivers are off while the ramp is below 500. Only `ls_en` is high from 500 to 1099. Both `hs_en` and `ls_en` are high from 1100 upward.
- R4: START moves to RUN (`phase` = 2) on the edge after the ramp code is at or above 3500. `sink_ok` is high only in RUN.
- R5: `oc_flag` high in START sets `cl_mode` on the next edge without leaving START. `cl_mode` stays set until the block leaves START, and it is 0 in every other phase.
- R6: `oc_flag` high in RUN moves the block to HICCUP (`phase` = 3) on the next edge. In HICCUP both drivers are off and the ramp falls by 10 per clock. HICCUP moves to START on the edge after the ramp code is at or below 500.
- R7: `ot_trip` high moves the block to THERMAL (`phase` = 4) from any phase on the next edge, with the ramp cleared to 0 and both drivers off. THERMAL is left only when `ot_recov` is high, `ot_trip` is low and the ramp is at or below 500. It then goes to START if both supply flags are high, and otherwise to OFF.
- R8: `ovp_flag` high forces `ls_en` high and `hs_en` low in every phase except THERMAL.
- R9: `rst_n` low at a clock edge returns the block to OFF with the ramp at 0 and `cl_mode` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vcc_ok | input | 1 | Supply above its turn-on threshold (hysteresis applied outside) |
| vin_ok | input | 1 | Input voltage above its turn-on threshold |
| oc_flag | input | 1 | Over-current detected (peak or valley) |
| ot_trip | input | 1 | Over-temperature trip |
| ot_recov | input | 1 | Temperature back below the recovery point |
| ovp_flag | input | 1 | Feedback over-voltage |
| ramp_code | output | RAMP_W | Soft-start ramp code, used as the reference clamp |
| hs_en | output | 1 | High-side driver may switch |
| ls_en | output | 1 | Low-side driver enabled |
| sink_ok | output | 1 | Reverse inductor current allowed |
| cl_mode | output | 1 | Constant-current limiting during soft-start |
| phase | output | 3 | Current phase code |

## Verification
The path hardest to reach from the ports is the hiccup restart. The bench must first carry the block through a complete soft-start, more than three hundred clocks, then trip over-current in RUN, and then wait out a discharge of about 350 clocks. Only then does the hand-back to START at the 500 boundary occur. The vector table holds each input pattern for exact cycle counts, so that the ramp lands on 510, then 500, then 510 again around that edge. The same long run also sets up the constant-current flag inside START and the thermal recovery path.

// File: rtl/softstart_pkg.sv
package softstart_pkg;

    typedef enum logic [2:0] {
        PH_OFF    = 3'd0,
        PH_START  = 3'd1,
        PH_RUN    = 3'd2,
        PH_HICCUP = 3'd3,
        PH_THERM  = 3'd4
    } phase_e;

    typedef enum logic [1:0] {
        RAMP_CLEAR     = 2'd0,
        RAMP_CHARGE    = 2'd1,
        RAMP_DISCHARGE = 2'd2
    } ramp_op_e;

endpackage

// File: rtl/ss_ramp.sv
module ss_ramp
    import softstart_pkg::*;
#(
    parameter int unsigned W          = 12,
    parameter int unsigned STEP_FAST  = 35,
    parameter int unsigned STEP_SLOW  = 10,
    parameter int unsigned CODE_KNEE  = 500,
    parameter int unsigned CODE_MAX   = 4000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ramp_op_e      op,
    output logic [W-1:0]  ramp_q
);

    localparam logic [W:0]   FAST_X = (W+1)'(STEP_FAST);
    localparam logic [W:0]   SLOW_X = (W+1)'(STEP_SLOW);
    localparam logic [W:0]   MAX_X  = (W+1)'(CODE_MAX);
    localparam logic [W-1:0] KNEE_C = W'(CODE_KNEE);
    localparam logic [W-1:0] SLOW_C = W'(STEP_SLOW);

    logic [W:0]   up_sum;
    logic [W-1:0] up_val;
    logic [W-1:0] down_val;
    logic [W-1:0] ramp_nx;

    always_comb begin
        up_sum   = {1'b0, ramp_q} + ((ramp_q < KNEE_C) ? FAST_X : SLOW_X);
        up_val   = (up_sum > MAX_X) ? MAX_X[W-1:0] : up_sum[W-1:0];
        down_val = (ramp_q > SLOW_C) ? (ramp_q - SLOW_C) : '0;
        unique case (op)
            RAMP_CHARGE:    ramp_nx = up_val;
            RAMP_DISCHARGE: ramp_nx = down_val;
            default:        ramp_nx = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ramp_q <= '0;
        else        ramp_q <= ramp_nx;
    end

    // R2: ramp never passes its ceiling
    a_r2_ramp_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_q <= MAX_X[W-1:0]);

    // R2: fast segment below the knee
    a_r2_fast_step: assert property (@(posedge clk) disable iff (!rst_n)
        (op == RAMP_CHARGE && ramp_q < KNEE_C) |=>
            (ramp_q == $past(ramp_q) + FAST_X[W-1:0]));

endmodule

// File: rtl/ss_phase_fsm.sv
module ss_phase_fsm
    import softstart_pkg::*;
#(
    parameter int unsigned W         = 12,
    parameter int unsigned CODE_OFF  = 500,
    parameter int unsigned CODE_DONE = 3500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_ok,
    input  logic          oc_flag,
    input  logic          ot_trip,
    input  logic          ot_recov,
    input  logic [W-1:0]  ramp_q,
    output phase_e        phase_q,
    output phase_e        phase_nx,
    output ramp_op_e      ramp_op,
    output logic          cl_q
);

    localparam logic [W-1:0] OFF_C  = W'(CODE_OFF);
    localparam logic [W-1:0] DONE_C = W'(CODE_DONE);

    // next-phase selection
    always_comb begin
        phase_nx = phase_q;
        if (ot_trip) begin
            phase_nx = PH_THERM;
        end else begin
            unique case (phase_q)
                PH_OFF: begin
                    if (pwr_ok) phase_nx = PH_START;
                end
                PH_START: begin
                    if (!pwr_ok)                phase_nx = PH_OFF;
                    else if (ramp_q >= DONE_C)  phase_nx = PH_RUN;
                end
                PH_RUN: begin
                    if (!pwr_ok)      phase_nx = PH_OFF;
                    else if (oc_flag) phase_nx = PH_HICCUP;
                end
                PH_HICCUP: begin
                    if (!pwr_ok)               phase_nx = PH_OFF;
                    else if (ramp_q <= OFF_C)  phase_nx = PH_START;
                end
                PH_THERM: begin
                    if (ot_recov && ramp_q <= OFF_C)
                        phase_nx = pwr_ok ? PH_START : PH_OFF;
                end
                default: phase_nx = PH_OFF;
            endcase
        end
    end

    // ramp command follows the phase being entered
    always_comb begin
        unique case (phase_nx)
            PH_START, PH_RUN: ramp_op = RAMP_CHARGE;
            PH_HICCUP:        ramp_op = RAMP_DISCHARGE;
            default:          ramp_op = RAMP_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_OFF;
            cl_q    <= 1'b0;
        end else begin
            phase_q <= phase_nx;
            cl_q    <= (phase_nx == PH_START) &&
                       (cl_q || (phase_q == PH_START && oc_flag));
        end
    end

    // R5: current-limit flag only inside soft-start
    a_r5_cl_in_start: assert property (@(posedge clk) disable iff (!rst_n)
        cl_q |-> (phase_q == PH_START));

    // R7: thermal trip wins from any phase
    a_r7_thermal_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ot_trip |=> (phase_q == PH_THERM));

    // R6: ramp keeps falling while hiccup persists
    a_r6_hiccup_discharge: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HICCUP && phase_nx == PH_HICCUP) |=> (ramp_q < $past(ramp_q)));

    // R4: soft-start only ends past the completion code
    a_r4_run_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_START && phase_nx == PH_RUN) |-> (ramp_q >= DONE_C));

endmodule

// File: rtl/ss_out_decode.sv
module ss_out_decode
    import softstart_pkg::*;
#(
    parameter int unsigned W         = 12,
    parameter int unsigned CODE_OFF  = 500,
    parameter int unsigned CODE_SW   = 1100,
    parameter int unsigned CODE_DONE = 3500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_e        phase_q,
    input  logic [W-1:0]  ramp_q,
    input  logic          ovp_flag,
    output logic          hs_en,
    output logic          ls_en,
    output logic          sink_ok
);

    localparam logic [W-1:0] OFF_C  = W'(CODE_OFF);
    localparam logic [W-1:0] SW_C   = W'(CODE_SW);
    localparam logic [W-1:0] DONE_C = W'(CODE_DONE);

    always_comb begin
        hs_en   = 1'b0;
        ls_en   = 1'b0;
        sink_ok = 1'b0;
        unique case (phase_q)
            PH_START, PH_RUN: begin
                ls_en   = (ramp_q >= OFF_C);
                hs_en   = (ramp_q >= SW_C);
                sink_ok = (phase_q == PH_RUN);
            end
            default: ;
        endcase
        if (ovp_flag && phase_q != PH_THERM) begin
            ls_en = 1'b1;
            hs_en = 1'b0;
        end
    end

    // R3: high side never switches below the switching code
    a_r3_hs_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |-> (ramp_q >= SW_C));

    // R4: sink only once the ramp has passed soft-start completion
    a_r4_sink_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        sink_ok |-> (ramp_q >= DONE_C));

    // R8: over-voltage pulls the low side on outside thermal shutdown
    a_r8_ovp_low_side: assert property (@(posedge clk) disable iff (!rst_n)
        (ovp_flag && phase_q != PH_THERM) |-> (ls_en && !hs_en));

    // R6/R7: quiet drivers in hiccup and thermal
    a_r6_hiccup_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_HICCUP && !ovp_flag) || phase_q == PH_THERM) |-> (!hs_en && !ls_en));

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
    import softstart_pkg::*;
#(
    parameter int unsigned RAMP_W    = 12,
    parameter int unsigned STEP_FAST = 35,
    parameter int unsigned STEP_SLOW = 10,
    parameter int unsigned CODE_OFF  = 500,
    parameter int unsigned CODE_SW   = 1100,
    parameter int unsigned CODE_DONE = 3500,
    parameter int unsigned CODE_MAX  = 4000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               vcc_ok,
    input  logic               vin_ok,
    input  logic               oc_flag,
    input  logic               ot_trip,
    input  logic               ot_recov,
    input  logic               ovp_flag,
    output logic [RAMP_W-1:0]  ramp_code,
    output logic               hs_en,
    output logic               ls_en,
    output logic               sink_ok,
    output logic               cl_mode,
    output logic [2:0]         phase
);

    phase_e            phase_q;
    phase_e            phase_nx;
    ramp_op_e          ramp_op;
    logic [RAMP_W-1:0] ramp_q;
    logic              pwr_ok;

    assign pwr_ok = vcc_ok & vin_ok;

    ss_phase_fsm #(
        .W         (RAMP_W),
        .CODE_OFF  (CODE_OFF),
        .CODE_DONE (CODE_DONE)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_ok   (pwr_ok),
        .oc_flag  (oc_flag),
        .ot_trip  (ot_trip),
        .ot_recov (ot_recov),
        .ramp_q   (ramp_q),
        .phase_q  (phase_q),
        .phase_nx (phase_nx),
        .ramp_op  (ramp_op),
        .cl_q     (cl_mode)
    );

    ss_ramp #(
        .W         (RAMP_W),
        .STEP_FAST (STEP_FAST),
        .STEP_SLOW (STEP_SLOW),
        .CODE_KNEE (CODE_OFF),
        .CODE_MAX  (CODE_MAX)
    ) u_ramp (
        .clk    (clk),
        .rst_n  (rst_n),
        .op     (ramp_op),
        .ramp_q (ramp_q)
    );

    ss_out_decode #(
        .W         (RAMP_W),
        .CODE_OFF  (CODE_OFF),
        .CODE_SW   (CODE_SW),
        .CODE_DONE (CODE_DONE)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_q  (phase_q),
        .ramp_q   (ramp_q),
        .ovp_flag (ovp_flag),
        .hs_en    (hs_en),
        .ls_en    (ls_en),
        .sink_ok  (sink_ok)
    );

    assign ramp_code = ramp_q;
    assign phase     = phase_q;

    // R1: disabled phase keeps the ramp empty
    a_r1_off_ramp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_OFF) |-> (ramp_q == '0));

    // R7: thermal trip clears the ramp on the next edge
    a_r7_thermal_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ot_trip |=> (ramp_q == '0));

    // R1: losing a supply flag drops to OFF unless a thermal event is in progress
    a_r1_power_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_ok && !ot_trip && phase_q != PH_THERM) |=> (phase_q == PH_OFF));

endmodule

// File: tb/softstart_seq_tb.sv
`timescale 1ns/1ps
module softstart_seq_tb;

    localparam int NROW = 22;

    // {vcc,vin,oc,ot,rec,ovp}[6] cycles[10] phase[3] ramp[12] {hs,ls,sink,cl}[4]
    localparam logic [34:0] VEC [NROW] = '{
        {6'b000000, 10'd5,   3'd0, 12'd0,    4'b0000},
        {6'b100000, 10'd3,   3'd0, 12'd0,    4'b0000},
        {6'b110000, 10'd14,  3'd1, 12'd490,  4'b0000},
        {6'b110000, 10'd1,   3'd1, 12'd525,  4'b0100},
        {6'b110000, 10'd57,  3'd1, 12'd1095, 4'b0100},
        {6'b110000, 10'd1,   3'd1, 12'd1105, 4'b1100},
        {6'b111000, 10'd1,   3'd1, 12'd1115, 4'b1101},
        {6'b110000, 10'd10,  3'd1, 12'd1215, 4'b1101},
        {6'b110000, 10'd229, 3'd1, 12'd3505, 4'b1101},
        {6'b110000, 10'd1,   3'd2, 12'd3515, 4'b1110},
        {6'b110000, 10'd100, 3'd2, 12'd4000, 4'b1110},
        {6'b110001, 10'd1,   3'd2, 12'd4000, 4'b0110},
        {6'b111000, 10'd1,   3'd3, 12'd3990, 4'b0000},
        {6'b110000, 10'd348, 3'd3, 12'd510,  4'b0000},
        {6'b110000, 10'd1,   3'd3, 12'd500,  4'b0000},
        {6'b110000, 10'd1,   3'd1, 12'd510,  4'b0100},
        {6'b110100, 10'd1,   3'd4, 12'd0,    4'b0000},
        {6'b110000, 10'd5,   3'd4, 12'd0,    4'b0000},
        {6'b110001, 10'd1,   3'd4, 12'd0,    4'b0000},
        {6'b110010, 10'd1,   3'd1, 12'd35,   4'b0000},
        {6'b100000, 10'd1,   3'd0, 12'd0,    4'b0000},
        {6'b100001, 10'd1,   3'd0, 12'd0,    4'b0100}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vcc_ok = 1'b0, vin_ok = 1'b0, oc_flag = 1'b0;
    logic        ot_trip = 1'b0, ot_recov = 1'b0, ovp_flag = 1'b0;
    logic [11:0] ramp_code;
    logic        hs_en, ls_en, sink_ok, cl_mode;
    logic [2:0]  phase;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    softstart_seq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .vcc_ok    (vcc_ok),
        .vin_ok    (vin_ok),
        .oc_flag   (oc_flag),
        .ot_trip   (ot_trip),
        .ot_recov  (ot_recov),
        .ovp_flag  (ovp_flag),
        .ramp_code (ramp_code),
        .hs_en     (hs_en),
        .ls_en     (ls_en),
        .sink_ok   (sink_ok),
        .cl_mode   (cl_mode),
        .phase     (phase)
    );

    function automatic string row_tag(int r);
        case (r)
            0, 1, 20:        return "R1";
            2, 3, 10:        return "R2";
            4, 5:            return "R3";
            8, 9:            return "R4";
            6, 7:            return "R5";
            12, 13, 14, 15:  return "R6";
            16, 17, 19:      return "R7";
            default:         return "R8";
        endcase
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic drive(logic [5:0] v);
        {vcc_ok, vin_ok, oc_flag, ot_trip, ot_recov, ovp_flag} = v;
    endtask

    task automatic run_cycles(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        drive(6'b000000);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: state straight out of reset
        check("R9", "phase after reset", phase, 0);
        check("R9", "ramp after reset", ramp_code, 0);
        check("R9", "cl after reset", cl_mode, 0);

        for (int r = 0; r < NROW; r++) begin
            logic [34:0] v;
            v = VEC[r];
            drive(v[34:29]);
            run_cycles(int'(v[28:19]));
            check(row_tag(r), $sformatf("row %0d phase", r), phase, int'(v[18:16]));
            check(row_tag(r), $sformatf("row %0d ramp", r), ramp_code, int'(v[15:4]));
            check(row_tag(r), $sformatf("row %0d hs_en", r), hs_en, int'(v[3]));
            check(row_tag(r), $sformatf("row %0d ls_en", r), ls_en, int'(v[2]));
            check(row_tag(r), $sformatf("row %0d sink/cl", r),
                  {30'd0, sink_ok, cl_mode}, int'(v[1:0]));
        end

        // R2: first fast step from an empty ramp
        drive(6'b110000);
        run_cycles(1);
        check("R2", "first step", ramp_code, 35);
        check("R2", "phase start", phase, 1);

        // R9: reset in the middle of soft-start with supplies still good
        run_cycles(19);
        check("R2", "ramp after 20 steps", ramp_code, 575);
        rst_n = 1'b0;
        run_cycles(1);
        rst_n = 1'b1;
        check("R9", "phase mid-run reset", phase, 0);
        check("R9", "ramp mid-run reset", ramp_code, 0);
        check("R9", "ls mid-run reset", ls_en, 0);

        // R7: thermal recovery with the input lost returns to OFF
        run_cycles(3);
        check("R1", "restart after reset", phase, 1);
        drive(6'b100100);
        run_cycles(1);
        check("R7", "thermal with input lost", phase, 4);
        drive(6'b100010);
        run_cycles(1);
        check("R7", "recover to off", phase, 0);
        check("R7", "ramp on recovery", ramp_code, 0);

        // R5: over-current in OFF sets no current-limit flag
        drive(6'b101000);
        run_cycles(3);
        check("R5", "cl in off", cl_mode, 0);
        check("R1", "phase held off", phase, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule